// File: doc/BRIEF.md
# Cascaded Synchronous Base-4 Digit Counter

This block is a multi-digit counter assembled from identical base-4 digit stages. Every stage holds a two-bit digit and runs from the one system clock. A stage steps forward when its enable is high. When it sits at 3 and is enabled, it raises a combinational carry, and that carry is the enable of the stage above. The chain of enables therefore decides which digits move, and every digit that moves changes on the same clock edge. No carry is ever used as a clock.

A single clear input reaches every stage, and it wins over the increment. One clear cycle returns the whole counter to zero. The digits are presented side by side on one bus, with the lowest digit in the least significant bits. The carry out of the top stage is also brought out, so a wider counter or other logic can see that the whole value is wrapping. A synchronous active-high reset sets the same state as a clear.

Top module: `cascade_counter`

## Requirements
- R1: After a cycle with reset high, every digit is 0 and the wrap output is low while the increment is low.
- R2: A clock edge with clear high sets every digit to 0, whatever the count is and whatever the increment input is.
- R3: On an edge where clear and increment are both low, every digit keeps its value.
- R4: With increment high and clear low, the lowest digit steps 0, 1, 2, 3 and then back to 0.
- R5: Digit k (k > 0) changes only on an edge where increment is high, clear is low and every digit below k is 3. All the digits that change do so on that same edge.
- R6: The wrap output is high, in the same cycle and with no register, exactly when increment is high, clear is low and every digit is 3. After it, the count is all zeros.
- R7: The digit bus, read as a base-4 number with digit k in bits [2k+1:2k], always equals the number of counted increments since the last clear or reset, modulo 4^N. With two digits and increment held high, it runs 00, 01, 02, 03, 10, ..., 33, 00.
- R8: Clear and increment both high while every digit is 3 give a wrap output of 0 in that cycle and an all-zero count after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock. All digit registers use this clock. |
| rst_i | input | 1 | Synchronous active-high reset. |
| clr_i | input | 1 | Synchronous clear of every digit. It has priority over increment. |
| inc_i | input | 1 | Increment enable for the lowest digit. |
| digits_o | output | 2*NUM_DIGITS | Digit values. Digit k is at bits [2k+1:2k]. |
| wrap_o | output | 1 | Combinational carry out of the top digit. |

## Verification
A digit register holding a wrong value shows on the digit bus at the very next sample after the faulty edge. This is because the bench compares every cycle against an integer model. A wrong carry shows within one edge in two ways: an upper digit moves early or late, and the wrap output is wrong in the same cycle it is sampled. A clear priority fault shows only when clear meets an enabled terminal count, so that exact case is driven on purpose.

// File: rtl/casc_pkg.sv
package casc_pkg;
  localparam int DIGIT_W_DEF    = 2;
  localparam int NUM_DIGITS_DEF = 3;

  function automatic int bus_width(input int digits, input int dw);
    return digits * dw;
  endfunction
endpackage

// File: rtl/digit_stage.sv
module digit_stage #(
  parameter int DW = casc_pkg::DIGIT_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [DW-1:0] val_o,
  output logic          carry_o
);
  localparam logic [DW-1:0] LAST = {DW{1'b1}};
  localparam logic [DW-1:0] ONE  = DW'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i)
      val_o <= '0;
    else if (inc_i)
      val_o <= val_o + ONE;
  end

  // Mealy carry: terminal value, enabled, not being cleared
  always_comb carry_o = inc_i && !clr_i && (val_o == LAST);

  // R2: clear empties the digit
  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (val_o == '0));

  // R3: idle digit holds
  p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !inc_i) |=> $stable(val_o));

  // R4: enabled digit steps by one with wrap
  p_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && inc_i) |=> (val_o == $past(val_o) + ONE));

  // R6: a carry leaves this digit at zero
  p_carry_then_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_o |=> (val_o == '0));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int NUM_DIGITS = casc_pkg::NUM_DIGITS_DEF,
  parameter int DIGIT_W    = casc_pkg::DIGIT_W_DEF
) (
  input  logic                                              clk_i,
  input  logic                                              rst_i,
  input  logic                                              clr_i,
  input  logic                                              inc_i,
  output logic [casc_pkg::bus_width(NUM_DIGITS, DIGIT_W)-1:0] digits_o,
  output logic                                              wrap_o
);
  localparam int BUS_W = casc_pkg::bus_width(NUM_DIGITS, DIGIT_W);

  logic [NUM_DIGITS:0] en_chain;

  always_comb en_chain[0] = inc_i;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    digit_stage #(.DW(DIGIT_W)) i_stage (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clr_i   (clr_i),
      .inc_i   (en_chain[k]),
      .val_o   (digits_o[k*DIGIT_W +: DIGIT_W]),
      .carry_o (en_chain[k+1])
    );

    if (k > 0) begin : g_upper_chk
      // R5: upper digit moves only when all lower digits are at terminal
      p_upper_moves_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && (!inc_i || digits_o[k*DIGIT_W-1:0] != {(k*DIGIT_W){1'b1}}))
        |=> $stable(digits_o[k*DIGIT_W +: DIGIT_W]));
    end
  end

  always_comb wrap_o = en_chain[NUM_DIGITS];

  // R6: wrap implies the whole count was at its top value
  p_wrap_at_top_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |-> (digits_o == {BUS_W{1'b1}}));

  // R8: clear suppresses wrap
  p_clear_no_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |-> !wrap_o);
endmodule

// File: tb/test_cascade_counter.sv
module test_cascade_counter;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 3;
  localparam int DW  = 2;
  localparam int W   = N * DW;
  localparam int MOD = 1 << W;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic clr_i = 1'b0;
  logic inc_i = 1'b0;
  logic [W-1:0] digits_o;
  logic wrap_o;

  cascade_counter #(.NUM_DIGITS(N), .DIGIT_W(DW)) i_cascade_counter (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_i), .inc_i(inc_i),
    .digits_o(digits_o), .wrap_o(wrap_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int ref_cnt = 0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, check wrap, push expected count
  task automatic step(input logic inc, input logic clr);
    item_t it;
    logic exp_wrap;
    @(negedge clk_i);
    inc_i = inc;
    clr_i = clr;
    #1;
    exp_wrap = inc && !clr && (ref_cnt == MOD-1);
    check(clr ? "R8 wrap" : "R6 wrap", W'(wrap_o), W'(exp_wrap));
    if (clr) it.tag = (inc && ref_cnt == MOD-1) ? "R8 count" : "R2 count";
    else if (!inc) it.tag = "R3 count";
    else if (ref_cnt % 4 == 3) it.tag = "R5 count";
    else it.tag = "R4 count";
    if (clr) ref_cnt = 0;
    else if (inc) ref_cnt = (ref_cnt + 1) % MOD;
    it.val = W'(ref_cnt);
    q.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " R7"}, digits_o, it.val);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    inc_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
    inc_i = 1'b0;
    #1;
    check("R1 reset digits", digits_o, '0);
    check("R1 reset wrap", W'(wrap_o), '0);

    // full run through all states and a wrap
    for (int i = 0; i < MOD + 5; i++) step(1'b1, 1'b0);
    // hold
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    // gapped increments
    for (int i = 0; i < 40; i++) step(i % 3 != 0, 1'b0);
    // clear mid count
    step(1'b0, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // climb to top value, then clear with increment at terminal
    while (ref_cnt != MOD-1) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    // top value again, gap at terminal, then wrap
    while (ref_cnt != MOD-1) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);

    repeat (3) @(posedge clk_i);
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule